// File: doc/BRIEF.md
# Multi-Cycle Instruction Cycle Sequencer

This block is the control unit and register set of a small accumulator machine. It moves each instruction through a fixed series of register transfer states. The fetch states move the program counter into the memory address register, read memory, capture the word in the memory buffer register and then in the instruction register. An optional indirect phase makes one extra memory read to find the effective address. The execute phase then performs one of four operations. At the end of every instruction the sequencer checks a level interrupt request. If it takes the interrupt, it pushes the program counter through the buffer register to the location the stack pointer names and jumps to a fixed handler.

An instruction word is `{opcode[2:0], ind, addr[11:0]}` at the default width. Memory is single-port and synchronous. Read data is expected one clock after the read request. Every memory access, read or write, occupies a state of its own.

The states, grouped by phase:

- Fetch: `ST_FI_ADDR` goes to `ST_FI_READ`, then `ST_FI_CAPT`, then `ST_FI_DECODE`. From `ST_FI_DECODE` the machine goes to `ST_IND_ADDR` when the indirect flag is set, and to `ST_EX_ADDR` otherwise.
- Indirect: `ST_IND_ADDR` goes to `ST_IND_READ`, then `ST_IND_CAPT`, then `ST_EX_ADDR`.
- Execute: from `ST_EX_ADDR`, LOAD and ADD go to `ST_EX_READ`, then `ST_EX_CAPT`, then `ST_EX_ALU`. STORE goes to `ST_EX_WRITE`. JUMP and the unused opcodes go straight to `ST_INT_CHK`. `ST_EX_ALU` and `ST_EX_WRITE` both go to `ST_INT_CHK`.
- Interrupt check: `ST_INT_CHK` goes to `ST_IE_SAVE` when an interrupt is pending and unmasked, and to `ST_FI_ADDR` otherwise.
- Interrupt entry: `ST_IE_SAVE` goes to `ST_IE_WRITE`, then `ST_IE_VECTOR`, then back to `ST_FI_ADDR`.

Top module: `icyc_seq`

## Requirements
- R1: While and after reset, the machine has the following state: the program counter and accumulator are 0, the stack pointer equals `SP_INIT`, interrupts are unmasked, and no read, write or acknowledge is driven. The first fetch reads address 0.
- R2: Each fetch issues one read at the program counter, and the program counter advances by exactly one during that fetch. The word read is decoded as opcode in bits [15:13], indirect flag in bit 12 and address in bits [11:0].
- R3: Read data is taken from `mem_rdata` in the clock after the read request. A read request is always followed by a cycle with no memory request. Read and write are never requested together.
- R4: With the indirect flag clear, the address field is the operand address. Opcode 0 (LOAD) copies the word read into the accumulator. Opcode 2 (ADD) adds the word read into the accumulator, modulo 2^16. Opcode 1 (STORE) writes the accumulator there with no read.
- R5: With the indirect flag set, one extra read is made at the address field. The low 12 bits of the word returned are the effective address, and the upper bits are ignored.
- R6: Opcode 3 (JUMP) loads the program counter with the effective address and makes no operand access. When it is indirect, its only extra access is the pointer read.
- R7: Opcodes 4 to 7 change neither the accumulator, the program counter flow nor memory. Beyond the fetch read and any pointer read, they make no access.
- R8: The interrupt request is sampled only after an instruction's last execute access. With no request pending, the next access is the fetch of the following instruction.
- R9: Interrupt entry has the following steps. It writes the address of the next instruction to the location the stack pointer holds, then decrements the stack pointer. It loads the program counter with `HANDLER` and pulses `irq_ack` for exactly one cycle, right after the push write. The next fetch reads `HANDLER`.
- R10: After an interrupt entry, further requests are ignored while `irq` stays high, until reset or `irq_unmask`.
- R11: A one-cycle `irq_unmask` pulse re-enables interrupts. A request that is still held is then taken at the next instruction end, and it is pushed to the next lower stack address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Memory address (address register) |
| mem_wdata | output | DATA_W | Memory write data (buffer register) |
| mem_rdata | input | DATA_W | Memory read data, valid the clock after `mem_rd` |
| irq | input | 1 | Level interrupt request |
| irq_ack | output | 1 | One-cycle interrupt acknowledge |
| irq_unmask | input | 1 | Clears the interrupt mask |
| pc_o | output | ADDR_W | Program counter |
| acc_o | output | DATA_W | Accumulator |

## Verification
The bench builds the block with the default 12-bit address field and two overridden parameters: `SP_INIT` = 0x3F0 and `HANDLER` = 0x200. These values place both the stack and the handler inside a 1K-word bench memory. With this setup, two interrupt entries can be observed writing to adjacent, descending stack words. The handler's own instructions can also be checked while the request line is held high and masked.

// File: rtl/icyc_pkg.sv
package icyc_pkg;

    localparam int OPC_W = 3;

    localparam logic [OPC_W-1:0] OPC_LOAD  = 3'd0;
    localparam logic [OPC_W-1:0] OPC_STORE = 3'd1;
    localparam logic [OPC_W-1:0] OPC_ADD   = 3'd2;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 3'd3;

    typedef enum logic [3:0] {
        ST_FI_ADDR,
        ST_FI_READ,
        ST_FI_CAPT,
        ST_FI_DECODE,
        ST_IND_ADDR,
        ST_IND_READ,
        ST_IND_CAPT,
        ST_EX_ADDR,
        ST_EX_READ,
        ST_EX_CAPT,
        ST_EX_ALU,
        ST_EX_WRITE,
        ST_INT_CHK,
        ST_IE_SAVE,
        ST_IE_WRITE,
        ST_IE_VECTOR
    } cyc_state_e;

    // register transfer strobes issued by the sequencer to the register set
    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_ir;
        logic mar_from_ea;
        logic mar_from_sp;
        logic pc_step;
        logic pc_from_ea;
        logic pc_to_vec;
        logic mbr_from_mem;
        logic mbr_from_acc;
        logic mbr_from_pc;
        logic ir_load;
        logic acc_load;
        logic acc_add;
        logic sp_dec;
        logic mask_set;
    } xfer_t;

endpackage

// File: rtl/icyc_ctrl.sv
module icyc_ctrl
    import icyc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mbr_ind,
    input  logic [OPC_W-1:0] ir_opc,
    input  logic             irq,
    input  logic             masked,
    output cyc_state_e       state_q,
    output xfer_t            xf,
    output logic             rd,
    output logic             wr,
    output logic             ack
);

    cyc_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FI_ADDR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FI_ADDR:   state_d = ST_FI_READ;
            ST_FI_READ:   state_d = ST_FI_CAPT;
            ST_FI_CAPT:   state_d = ST_FI_DECODE;
            ST_FI_DECODE: state_d = mbr_ind ? ST_IND_ADDR : ST_EX_ADDR;
            ST_IND_ADDR:  state_d = ST_IND_READ;
            ST_IND_READ:  state_d = ST_IND_CAPT;
            ST_IND_CAPT:  state_d = ST_EX_ADDR;
            ST_EX_ADDR: begin
                if (ir_opc == OPC_LOAD || ir_opc == OPC_ADD) state_d = ST_EX_READ;
                else if (ir_opc == OPC_STORE)                state_d = ST_EX_WRITE;
                else                                         state_d = ST_INT_CHK;
            end
            ST_EX_READ:   state_d = ST_EX_CAPT;
            ST_EX_CAPT:   state_d = ST_EX_ALU;
            ST_EX_ALU:    state_d = ST_INT_CHK;
            ST_EX_WRITE:  state_d = ST_INT_CHK;
            ST_INT_CHK:   state_d = (irq && !masked) ? ST_IE_SAVE : ST_FI_ADDR;
            ST_IE_SAVE:   state_d = ST_IE_WRITE;
            ST_IE_WRITE:  state_d = ST_IE_VECTOR;
            ST_IE_VECTOR: state_d = ST_FI_ADDR;
        endcase
    end

    always_comb begin
        xf  = '0;
        rd  = 1'b0;
        wr  = 1'b0;
        ack = 1'b0;
        unique case (state_q)
            ST_FI_ADDR:   xf.mar_from_pc = 1'b1;
            ST_FI_READ: begin
                rd         = 1'b1;
                xf.pc_step = 1'b1;
            end
            ST_FI_CAPT:   xf.mbr_from_mem = 1'b1;
            ST_FI_DECODE: xf.ir_load = 1'b1;
            ST_IND_ADDR:  xf.mar_from_ir = 1'b1;
            ST_IND_READ:  rd = 1'b1;
            ST_IND_CAPT:  xf.mbr_from_mem = 1'b1;
            ST_EX_ADDR: begin
                xf.mar_from_ea  = 1'b1;
                xf.mbr_from_acc = (ir_opc == OPC_STORE);
                xf.pc_from_ea   = (ir_opc == OPC_JUMP);
            end
            ST_EX_READ:   rd = 1'b1;
            ST_EX_CAPT:   xf.mbr_from_mem = 1'b1;
            ST_EX_ALU: begin
                xf.acc_load = (ir_opc == OPC_LOAD);
                xf.acc_add  = (ir_opc != OPC_LOAD);
            end
            ST_EX_WRITE:  wr = 1'b1;
            ST_INT_CHK:   ;
            ST_IE_SAVE: begin
                xf.mbr_from_pc = 1'b1;
                xf.mar_from_sp = 1'b1;
            end
            ST_IE_WRITE: begin
                wr        = 1'b1;
                xf.sp_dec = 1'b1;
            end
            ST_IE_VECTOR: begin
                xf.pc_to_vec = 1'b1;
                xf.mask_set  = 1'b1;
                ack          = 1'b1;
            end
        endcase
    end

    // R8
    entry_from_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IE_SAVE) |-> ($past(state_q) == ST_INT_CHK));

endmodule

// File: rtl/icyc_dpath.sv
module icyc_dpath
    import icyc_pkg::*;
#(
    parameter int                ADDR_W  = 12,
    parameter int                DATA_W  = OPC_W + 1 + ADDR_W,
    parameter logic [ADDR_W-1:0] SP_INIT = '1,
    parameter logic [ADDR_W-1:0] HANDLER = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  xfer_t             xf,
    input  logic              irq_unmask,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mar_q,
    output logic [DATA_W-1:0] mbr_q,
    output logic [ADDR_W-1:0] pc_q,
    output logic [DATA_W-1:0] acc_q,
    output logic              mbr_ind,
    output logic [OPC_W-1:0]  ir_opc,
    output logic              masked_q
);

    localparam int IND_BIT = ADDR_W;
    localparam int PAD_W   = DATA_W - ADDR_W;

    logic [DATA_W-1:0] ir_q;
    logic [ADDR_W-1:0] sp_q;
    logic [ADDR_W-1:0] ea;

    // effective address: pointer word after an indirect read, else the address field
    assign ea      = ir_q[IND_BIT] ? mbr_q[ADDR_W-1:0] : ir_q[ADDR_W-1:0];
    assign mbr_ind = mbr_q[IND_BIT];
    assign ir_opc  = ir_q[DATA_W-1 -: OPC_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q     <= '0;
            mar_q    <= '0;
            mbr_q    <= '0;
            ir_q     <= '0;
            acc_q    <= '0;
            sp_q     <= SP_INIT;
            masked_q <= 1'b0;
        end else begin
            if (xf.pc_to_vec)       pc_q <= HANDLER;
            else if (xf.pc_from_ea) pc_q <= ea;
            else if (xf.pc_step)    pc_q <= pc_q + 1'b1;

            if (xf.mar_from_pc)      mar_q <= pc_q;
            else if (xf.mar_from_ir) mar_q <= ir_q[ADDR_W-1:0];
            else if (xf.mar_from_ea) mar_q <= ea;
            else if (xf.mar_from_sp) mar_q <= sp_q;

            if (xf.mbr_from_mem)      mbr_q <= mem_rdata;
            else if (xf.mbr_from_acc) mbr_q <= acc_q;
            else if (xf.mbr_from_pc)  mbr_q <= {{PAD_W{1'b0}}, pc_q};

            if (xf.ir_load) ir_q <= mbr_q;

            if (xf.acc_load)     acc_q <= mbr_q;
            else if (xf.acc_add) acc_q <= acc_q + mbr_q;

            if (xf.sp_dec) sp_q <= sp_q - 1'b1;

            if (xf.mask_set)    masked_q <= 1'b1;
            else if (irq_unmask) masked_q <= 1'b0;
        end
    end

    // R10
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_q && !irq_unmask) |=> masked_q);

endmodule

// File: rtl/icyc_seq.sv
module icyc_seq
    import icyc_pkg::*;
#(
    parameter int                ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] SP_INIT = '1,
    parameter logic [ADDR_W-1:0] HANDLER = '0,
    localparam int               DATA_W  = OPC_W + 1 + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              irq,
    output logic              irq_ack,
    input  logic              irq_unmask,
    output logic [ADDR_W-1:0] pc_o,
    output logic [DATA_W-1:0] acc_o
);

    cyc_state_e       state;
    xfer_t            xf;
    logic             mbr_ind;
    logic [OPC_W-1:0] ir_opc;
    logic             masked;

    icyc_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .mbr_ind (mbr_ind),
        .ir_opc  (ir_opc),
        .irq     (irq),
        .masked  (masked),
        .state_q (state),
        .xf      (xf),
        .rd      (mem_rd),
        .wr      (mem_wr),
        .ack     (irq_ack)
    );

    icyc_dpath #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .SP_INIT (SP_INIT),
        .HANDLER (HANDLER)
    ) u_dpath (
        .clk        (clk),
        .rst_n      (rst_n),
        .xf         (xf),
        .irq_unmask (irq_unmask),
        .mem_rdata  (mem_rdata),
        .mar_q      (mem_addr),
        .mbr_q      (mem_wdata),
        .pc_q       (pc_o),
        .acc_q      (acc_o),
        .mbr_ind    (mbr_ind),
        .ir_opc     (ir_opc),
        .masked_q   (masked)
    );

    // R3
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R3
    read_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !(mem_rd || mem_wr));

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FI_READ) |=> (pc_o == $past(pc_o) + 1'b1));

    // R9
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_ack);

    // R9
    ack_after_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> $past(mem_wr));

    // R10
    mask_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> masked);

endmodule

// File: tb/icyc_seq_tb.sv
`timescale 1ns/1ps
module icyc_seq_tb;

    localparam logic [11:0] SP0  = 12'h3F0;
    localparam logic [11:0] HVEC = 12'h200;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mem_rd, mem_wr, irq, irq_ack, irq_unmask;
    logic [11:0] mem_addr, pc_o;
    logic [15:0] mem_wdata, mem_rdata, acc_o;

    always #5 clk = ~clk;

    icyc_seq #(.ADDR_W(12), .SP_INIT(SP0), .HANDLER(HVEC)) u_dut (
        .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .irq(irq), .irq_ack(irq_ack), .irq_unmask(irq_unmask),
        .pc_o(pc_o), .acc_o(acc_o)
    );

    // bench memory: preload port has priority over the design's write
    logic [15:0] mem [0:1023];
    logic        pl_we;
    logic [9:0]  pl_addr;
    logic [15:0] pl_data;

    always @(posedge clk) begin
        if (pl_we)       mem[pl_addr] <= pl_data;
        else if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
        if (mem_rd)      mem_rdata <= mem[mem_addr[9:0]];
    end

    // scoreboard
    typedef struct {
        bit          wr;
        logic [11:0] addr;
        logic [15:0] data;
        string       tag;
    } xact_t;
    xact_t q[$];

    int checks = 0, errs = 0, mon_checks = 0, mon_errs = 0;
    int hunt_req = 0, hunt_done = 0, ack_cnt = 0;

    always @(negedge clk) begin
        if (rst_n && irq_ack) ack_cnt++;
    end

    always @(negedge clk) begin
        xact_t e;
        if (rst_n && (mem_rd || mem_wr)) begin
            if (!(hunt_done < hunt_req && !mem_wr)) begin
                if (hunt_done < hunt_req) hunt_done++;
                if (q.size() > 0) begin
                    e = q.pop_front();
                    mon_checks++;
                    if (mem_wr !== e.wr || mem_addr !== e.addr ||
                        (e.wr && mem_wdata !== e.data)) begin
                        mon_errs++;
                        $display("FAIL %s access: got wr=%0b addr=%h data=%h expected wr=%0b addr=%h data=%h",
                                 e.tag, mem_wr, mem_addr, mem_wdata, e.wr, e.addr, e.data);
                    end
                end
            end
        end
    end

    // reference model of the instruction set
    logic [15:0] mm [0:1023];
    logic [11:0] m_pc, m_sp;
    logic [15:0] m_acc;
    bit          m_mask, m_irq;

    function automatic logic [15:0] enc(int op, int ind, int a);
        return {op[2:0], ind[0], a[11:0]};
    endfunction

    task automatic push(bit wr, logic [11:0] a, logic [15:0] d, string tag);
        xact_t e;
        e.wr = wr; e.addr = a; e.data = d; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic m_reset();
        m_pc = '0; m_acc = '0; m_sp = SP0; m_mask = 1'b0;
    endtask

    task automatic m_entry();
        push(1'b1, m_sp, {4'h0, m_pc}, "R9");
        mm[m_sp[9:0]] = {4'h0, m_pc};
        m_sp   = m_sp - 1'b1;
        m_pc   = HVEC;
        m_mask = 1'b1;
    endtask

    task automatic m_instr(output bit self_loop);
        logic [15:0] w;
        logic [11:0] here, ea;
        self_loop = 1'b0;
        here = m_pc;
        w    = mm[here[9:0]];
        push(1'b0, here, '0, "R2");
        m_pc = here + 1'b1;
        ea   = w[11:0];
        if (w[12]) begin
            push(1'b0, ea, '0, "R5");
            ea = mm[ea[9:0]][11:0];
        end
        case (w[15:13])
            3'd0: begin push(1'b0, ea, '0, "R4"); m_acc = mm[ea[9:0]]; end
            3'd2: begin push(1'b0, ea, '0, "R4"); m_acc = m_acc + mm[ea[9:0]]; end
            3'd1: begin push(1'b1, ea, m_acc, "R4"); mm[ea[9:0]] = m_acc; end
            3'd3: begin m_pc = ea; self_loop = (ea == here); end
            default: ;
        endcase
    endtask

    task automatic m_run();
        bit done = 1'b0;
        while (!done) begin
            m_instr(done);
            if (m_irq && !m_mask) m_entry();
        end
    endtask

    task automatic put(int a, logic [15:0] d);
        mm[a] = d;
        @(negedge clk);
        pl_we = 1'b1; pl_addr = a[9:0]; pl_data = d;
        @(negedge clk);
        pl_we = 1'b0;
    endtask

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wait_drain(int limit);
        int n = 0;
        while (q.size() != 0 && n < limit) begin
            @(negedge clk);
            n++;
        end
        if (q.size() != 0) begin
            checks++; errs++;
            $display("FAIL R2 drain: got %0d pending expected 0", q.size());
        end
    endtask

    task automatic reset_checks();
        chk("R1 pc", {20'h0, pc_o}, 32'h0);
        chk("R1 acc", {16'h0, acc_o}, 32'h0);
        chk("R1 rd", {31'h0, mem_rd}, 32'h0);
        chk("R1 wr", {31'h0, mem_wr}, 32'h0);
        chk("R1 ack", {31'h0, irq_ack}, 32'h0);
    endtask

    initial begin
        int ack_base;
        rst_n = 1'b0; irq = 1'b0; irq_unmask = 1'b0; pl_we = 1'b0;
        pl_addr = '0; pl_data = '0;

        // ---------- segment A: direct, indirect, jumps, unused opcode ----------
        put(12'h100, 16'h0011);
        put(12'h101, 16'h0022);
        put(12'h103, 16'hF104);          // pointer, upper bits must be ignored
        put(12'h104, 16'h1234);
        put(12'h105, 16'h0106);
        put(12'h106, 16'h0100);
        put(12'h107, 16'h0108);
        put(12'h109, 16'h3020);
        put(12'h000, enc(0, 0, 12'h100));
        put(12'h001, enc(2, 0, 12'h101));
        put(12'h002, enc(1, 0, 12'h102));
        put(12'h003, enc(0, 1, 12'h103));
        put(12'h004, enc(2, 1, 12'h105));
        put(12'h005, enc(1, 1, 12'h107));
        put(12'h006, enc(5, 0, 12'h100));
        put(12'h007, enc(3, 0, 12'h010));
        put(12'h010, enc(3, 1, 12'h109));
        put(12'h020, enc(2, 0, 12'h101));
        put(12'h021, enc(3, 0, 12'h021));
        m_reset(); m_irq = 1'b0; m_run();
        @(negedge clk);
        reset_checks();
        ack_base = ack_cnt;
        rst_n = 1'b1;
        wait_drain(3000);
        repeat (20) @(negedge clk);
        chk("R3 acc captured from delayed read data", {16'h0, acc_o}, {16'h0, m_acc});
        chk("R4 direct store", {16'h0, mem[12'h102]}, 32'h0033);
        chk("R5 indirect store", {16'h0, mem[12'h108]}, 32'h1334);
        chk("R6 indirect jump reached target", {31'h0, (pc_o == 12'h021 || pc_o == 12'h022)}, 32'h1);
        chk("R7 unused opcode left memory", {16'h0, mem[12'h100]}, 32'h0011);
        chk("R8 no ack without request", ack_cnt - ack_base, 0);

        // ---------- segment B: interrupt entry, mask, unmask ----------
        @(negedge clk);
        rst_n = 1'b0;
        irq   = 1'b1;
        put(12'h000, enc(0, 0, 12'h100));
        put(12'h001, enc(2, 0, 12'h101));
        put(HVEC,          enc(2, 0, 12'h101));
        put(HVEC + 12'h1,  enc(3, 0, HVEC + 12'h1));
        m_reset(); m_irq = 1'b1; m_run();
        @(negedge clk);
        reset_checks();
        ack_base = ack_cnt;
        rst_n = 1'b1;
        wait_drain(3000);
        repeat (60) @(negedge clk);
        chk("R9 push of return address", {16'h0, mem[SP0]}, 32'h0001);
        chk("R9 handler executed", {16'h0, acc_o}, 32'h0033);
        chk("R9 pc in handler loop", {31'h0, (pc_o == HVEC + 12'h1 || pc_o == HVEC + 12'h2)}, 32'h1);
        chk("R10 single ack while held and masked", ack_cnt - ack_base, 1);

        // re-enable: held request is taken at the next instruction end
        m_entry(); m_run();
        hunt_req++;
        irq_unmask = 1'b1;
        @(negedge clk);
        irq_unmask = 1'b0;
        wait_drain(3000);
        repeat (60) @(negedge clk);
        chk("R11 second ack after unmask", ack_cnt - ack_base, 2);
        chk("R11 push to next lower stack word", {16'h0, mem[SP0 - 12'h1]}, {20'h0, HVEC + 12'h1});
        chk("R11 handler ran again", {16'h0, acc_o}, 32'h0055);

        $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errs + mon_errs);
        $finish;
    end

    initial begin
        #1500000;
        $display("FAIL R1 watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks + mon_checks + 1, errs + mon_errs + 1);
        $finish;
    end

endmodule